// File: doc/BRIEF.md
# Chained Rectangle Refill Engine for a Page Table

The engine rewrites a rectangular window of a two-dimensional page lookup table using a zero-terminated linked list of descriptors held in memory. Software writes the address of the first descriptor into the pointer register. The engine then reads that descriptor's five header words through a single-outstanding memory read port. It streams the rectangle's page entries from memory into the table one entry per returned word, and moves on to the next descriptor until a null link ends the chain.

Progress is reported in three ways. A status register holds a ready bit and an error bit. An eight-bit interrupt status group sits at a lane chosen by the engine number and is cleared by writing ones. A level interrupt output is raised whenever an enabled status bit is set. A programmable row offset is added to every row coordinate, so that one chain can target an upper region of a taller table.

Top module: `refill_engine`

## Requirements
- R1: After reset, the status register reads 0x1 (ready, no error), the interrupt status, enable and pointer registers read 0, `irq` is low, and neither `mem_req` nor `tbl_we` is asserted.
- R2: The pointer register is at address 0. Writing a value whose bits [31:4] are not all zero starts a chain at that value with bits [3:0] cleared. Reading the register returns the last value written.
- R3: Each descriptor is five words, at byte offsets +0 `{y0[31:16], x0[15:0]}`, +4 `{y1, x1}`, +8 control (bit 0 = enable, bits [11:8] = table id), +12 data pointer and +16 link pointer.
- R4: An enabled descriptor writes (1+x1−x0)×(1+y1−y0) entries in row-major order (x fastest). The data comes from consecutive words starting at the data pointer, with bits [3:0] ignored. The index is (y + row offset)×TBL_W + x, and `tbl_id` carries the control field. The row offset register is at address 4.
- R5: The engine follows link pointers. A link whose bits [31:4] are all zero ends the chain and sets bit 2 (done) of the interrupt group.
- R6: A descriptor whose enable bit is 0 writes nothing to the table, and the chain continues through its link.
- R7: A descriptor with x1<x0, y1<y0, x1≥TBL_W or y1 + row offset ≥ TBL_H causes no writes. It sets the error bit and bit 3 of the interrupt group, and the chain stops.
- R8: The status register is at address 1. Bit 0 (ready) is 1 only while the engine is idle, and bit 1 holds the error flag. Starting a new chain clears the error flag.
- R9: Writing a pointer value whose bits [31:4] are zero cancels a running chain. No further memory requests or table writes occur, and done is not set.
- R10: The interrupt status is at address 2, in bits [8·ENG_ID+7 : 8·ENG_ID]. Bit 7 is set each time a descriptor header has been fetched, and bit 0 is never set by this engine. Writing a 1 to a bit clears it; writing a 0 leaves it unchanged.
- R11: The enable register is at address 3, in the same lane as the status. `irq` is high exactly when status AND enable is nonzero, so an enable of 0x7E masks bits 0 and 7.
- R12: `mem_req` and `mem_addr` hold steady until `mem_rvalid`. Each data word returned during a rectangle produces exactly one table write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Read data |
| tbl_we | output | 1 | Table entry write strobe |
| tbl_idx | output | $clog2(TBL_W·TBL_H) | Table entry index |
| tbl_id | output | TID_W | Table id from the descriptor control word |
| tbl_data | output | 32 | Page entry written |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a cancel that arrives in the middle of a rectangle while a memory read is still waiting. In that case no stale word may turn into a table write, and no done bit may appear. The bench's memory model stretches response latency over a repeating zero-to-two cycle pattern. It counts table writes as they match its queue, and it issues the cancel only after several entries of a 64-entry rectangle have gone through. Error detection midway through a chain, after one good descriptor, is reached by linking a valid descriptor to a malformed one.

// File: rtl/refill_engine.sv
module refill_engine #(
  parameter int TBL_W  = 16,
  parameter int TBL_H  = 16,
  parameter int TID_W  = 4,
  parameter int YOFF_W = 8,
  parameter int ENG_ID = 1,
  localparam int IDX_W = $clog2(TBL_W * TBL_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              tbl_we,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic [TID_W-1:0]  tbl_id,
  output logic [31:0]       tbl_data,
  output logic              irq
);
  localparam int GRP = 8 * ENG_ID;
  localparam logic [2:0] A_PTR = 3'd0, A_STAT = 3'd1, A_IST = 3'd2, A_IEN = 3'd3, A_YOFF = 3'd4;
  localparam int B_DONE = 2, B_ERR = 3, B_FILL = 7;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA} st_t;
  st_t st;

  logic [31:0]       ptr_wr_q, ptr_q;
  logic [27:0]       dptr_q, next_q;
  logic [15:0]       x0_q, y0_q, x1_q, y1_q, cx_q, cy_q;
  logic              en_q;
  logic [TID_W-1:0]  tid_q;
  logic [2:0]        hcnt_q;
  logic              err_q;
  logic [7:0]        ist_q, ien_q;
  logic [YOFF_W-1:0] yoff_q;

  logic ptr_wr, go, hdr_end, rect_end, bad, ev_err, ev_done;
  logic [16:0] ylast, yabs;
  logic [7:0] ev_set, ev_clr;

  assign ptr_wr   = reg_we && reg_addr == A_PTR;
  assign go       = ptr_wr && |reg_wdata[31:4];
  assign hdr_end  = st == S_HDR && mem_rvalid && hcnt_q == 3'd4 && !ptr_wr;
  assign rect_end = st == S_DATA && mem_rvalid && cx_q == x1_q && cy_q == y1_q && !ptr_wr;
  assign ylast    = {1'b0, y1_q} + 17'(yoff_q);
  assign yabs     = {1'b0, cy_q} + 17'(yoff_q);
  assign bad      = (x1_q < x0_q) || (y1_q < y0_q) ||
                    (32'(x1_q) >= 32'(TBL_W)) || (32'(ylast) >= 32'(TBL_H));
  assign ev_err   = hdr_end && bad;
  assign ev_done  = (hdr_end && !bad && !en_q && ~|mem_rdata[31:4]) ||
                    (rect_end && ~|next_q);
  assign ev_set   = (8'(hdr_end) << B_FILL) | (8'(ev_done) << B_DONE) | (8'(ev_err) << B_ERR);
  assign ev_clr   = (reg_we && reg_addr == A_IST) ? reg_wdata[GRP +: 8] : 8'h00;

  assign mem_req  = st != S_IDLE;
  assign mem_addr = ptr_q;
  assign tbl_we   = st == S_DATA && mem_rvalid && !ptr_wr;
  assign tbl_idx  = IDX_W'(32'(yabs) * 32'(TBL_W) + 32'(cx_q));
  assign tbl_id   = tid_q;
  assign tbl_data = mem_rdata;
  assign irq      = |(ist_q & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr_wr_q <= '0;
      ptr_q    <= '0;
      dptr_q   <= '0;
      next_q   <= '0;
      x0_q     <= '0;
      y0_q     <= '0;
      x1_q     <= '0;
      y1_q     <= '0;
      cx_q     <= '0;
      cy_q     <= '0;
      en_q     <= 1'b0;
      tid_q    <= '0;
      hcnt_q   <= '0;
      err_q    <= 1'b0;
    end else if (ptr_wr) begin
      ptr_wr_q <= reg_wdata;
      ptr_q    <= {reg_wdata[31:4], 4'h0};
      hcnt_q   <= '0;
      st       <= go ? S_HDR : S_IDLE;
      if (go) err_q <= 1'b0;
    end else begin
      case (st)
        S_HDR: if (mem_rvalid) begin
          ptr_q  <= ptr_q + 32'd4;
          hcnt_q <= hcnt_q + 3'd1;
          case (hcnt_q)
            3'd0: {y0_q, x0_q} <= mem_rdata;
            3'd1: {y1_q, x1_q} <= mem_rdata;
            3'd2: begin
              en_q  <= mem_rdata[0];
              tid_q <= mem_rdata[8 +: TID_W];
            end
            3'd3: dptr_q <= mem_rdata[31:4];
            default: next_q <= mem_rdata[31:4];
          endcase
          if (hdr_end) begin
            hcnt_q <= '0;
            if (bad) begin
              err_q <= 1'b1;
              st    <= S_IDLE;
            end else if (!en_q) begin
              if (~|mem_rdata[31:4]) st <= S_IDLE;
              else ptr_q <= {mem_rdata[31:4], 4'h0};
            end else begin
              st    <= S_DATA;
              ptr_q <= {dptr_q, 4'h0};
              cx_q  <= x0_q;
              cy_q  <= y0_q;
            end
          end
        end
        S_DATA: if (mem_rvalid) begin
          ptr_q <= ptr_q + 32'd4;
          if (cx_q != x1_q) begin
            cx_q <= cx_q + 16'd1;
          end else begin
            cx_q <= x0_q;
            if (cy_q != y1_q) begin
              cy_q <= cy_q + 16'd1;
            end else if (~|next_q) begin
              st <= S_IDLE;
            end else begin
              st     <= S_HDR;
              hcnt_q <= '0;
              ptr_q  <= {next_q, 4'h0};
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist_q  <= '0;
      ien_q  <= '0;
      yoff_q <= '0;
    end else begin
      ist_q <= (ist_q & ~ev_clr) | ev_set;
      if (reg_we && reg_addr == A_IEN)  ien_q  <= reg_wdata[GRP +: 8];
      if (reg_we && reg_addr == A_YOFF) yoff_q <= reg_wdata[YOFF_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_PTR:   reg_rdata = ptr_wr_q;
      A_STAT:  reg_rdata = {30'd0, err_q, st == S_IDLE};
      A_IST:   reg_rdata = 32'(ist_q) << GRP;
      A_IEN:   reg_rdata = 32'(ien_q) << GRP;
      A_YOFF:  reg_rdata = 32'(yoff_q);
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/refill_engine_chk.sv
module refill_engine_chk #(
  parameter int ENG_ID = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        tbl_we,
  input logic        irq
);
  localparam int GRP = 8 * ENG_ID;

  // R12: request and address stay put while no data has returned
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid && !reg_we) |=> (mem_req && $stable(mem_addr)));

  // R12: a table write only accompanies returned data
  p_write_on_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (mem_req && mem_rvalid));

  // R9: a null pointer write leaves the engine quiet
  p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && reg_wdata[31:4] == 28'd0) |=> (!mem_req && !tbl_we));

  // R2: a start fetches from the aligned pointer
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && reg_wdata[31:4] != 28'd0) |=>
      (mem_req && mem_addr == {$past(reg_wdata[31:4]), 4'h0}));

  // R2: pointer register reads back what was written
  p_ptr_rb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0) |=> (reg_addr != 3'd0 || reg_rdata == $past(reg_wdata)));

  // R11: zero enable silences the interrupt
  p_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd3 && reg_wdata[GRP +: 8] == 8'd0) |=> !irq);

  // R3: fetch addresses are word aligned
  p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
endmodule

bind refill_engine refill_engine_chk #(.ENG_ID(ENG_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .tbl_we(tbl_we), .irq(irq)
);

// File: tb/refill_engine_tb.sv
module refill_engine_tb;
  localparam int TW = 16, TH = 16, ENG = 1, IW = $clog2(TW * TH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic tbl_we, irq;
  logic [IW-1:0] tbl_idx;
  logic [3:0] tbl_id;
  logic [31:0] tbl_data;

  always #4 clk = ~clk;

  refill_engine #(.TBL_W(TW), .TBL_H(TH), .TID_W(4), .YOFF_W(8), .ENG_ID(ENG)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_id(tbl_id),
    .tbl_data(tbl_data), .irq(irq));

  int n_chk = 0, n_fail = 0, n_wr = 0;
  int unsigned mem [int unsigned];
  int q_idx[$], q_dat[$], q_tid[$];
  int yoff_m = 0, lat_mode = 0, lat_ctr = 0, wait_cnt = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic int next_lat();
    if (lat_mode == 0) return 0;
    lat_ctr = (lat_ctr + 1) % 3;
    return lat_ctr;
  endfunction

  // memory responder and per-cycle table write comparison against the model queue
  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      wait_cnt = next_lat();
    end
    if (rst_n && mem_req) begin
      if (wait_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'd0;
      end else wait_cnt--;
    end
    #1;
    if (tbl_we) begin
      n_wr++;
      if (q_idx.size() == 0) chk("R4 unexpected table write", 32'(tbl_idx), 32'hFFFF_FFFF);
      else begin
        chk("R4 index", 32'(tbl_idx), 32'(q_idx.pop_front()));
        chk("R4 data", tbl_data, 32'(q_dat.pop_front()));
        chk("R4 table id", 32'(tbl_id), 32'(q_tid.pop_front()));
      end
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      reg_rd(3'd1, s);
      if (s[0]) return;
    end
    chk("R8 engine never returned to idle", 32'd0, 32'd1);
  endtask

  // builds a descriptor and its data in memory; queues the writes it should cause
  task automatic add_desc(input int a, input int x0, input int y0, input int x1, input int y1,
                          input int en, input int tid, input int dp, input int nx, input int seed);
    int k;
    mem[a]      = (y0 << 16) | x0;
    mem[a + 4]  = (y1 << 16) | x1;
    mem[a + 8]  = (tid << 8) | en;
    mem[a + 12] = dp;
    mem[a + 16] = nx;
    k = 0;
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        mem[(dp & ~15) + 4 * k] = seed + k * 32'h101;
        if (en != 0) begin
          q_idx.push_back(((y + yoff_m) * TW + x) % (TW * TH));
          q_dat.push_back(seed + k * 32'h101);
          q_tid.push_back(tid);
        end
        k++;
      end
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish();
  end

  initial begin
    logic [31:0] v;
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(3'd1, v); chk("R1 status", v, 32'h1);
    reg_rd(3'd2, v); chk("R1 irq status", v, 32'h0);
    reg_rd(3'd3, v); chk("R1 irq enable", v, 32'h0);
    reg_rd(3'd0, v); chk("R1 pointer", v, 32'h0);
    chk("R1 irq/mem_req/tbl_we", {irq, mem_req, tbl_we}, 3'b000);

    // single rectangle, zero latency: R3 R4 R5 R8 R10 R12
    add_desc(32'h100, 1, 2, 3, 3, 1, 5, 32'h400, 0, 32'h1000);
    w0 = n_wr;
    reg_wr(3'd0, 32'h100);
    reg_rd(3'd1, v); chk("R8 ready low while busy", v, 32'h0);
    wait_idle();
    chk("R4 all queued writes seen", q_idx.size(), 0);
    chk("R12 one write per entry", n_wr - w0, 6);
    reg_rd(3'd1, v); chk("R8 ready after done", v, 32'h1);
    reg_rd(3'd2, v); chk("R5 R10 done and fill bits in lane", v, 32'h84 << (8 * ENG));
    reg_rd(3'd0, v); chk("R2 pointer readback", v, 32'h100);

    // R11 masking and R10 write-one-to-clear
    reg_wr(3'd3, 32'h00 << (8 * ENG)); #2 chk("R11 irq masked by zero enable", irq, 1'b0);
    reg_wr(3'd3, 32'h04 << (8 * ENG)); #2 chk("R11 irq on enabled done", irq, 1'b1);
    reg_wr(3'd3, 32'h7E << (8 * ENG)); #2 chk("R11 irq with 0x7E", irq, 1'b1);
    reg_wr(3'd2, 32'h04 << (8 * ENG));
    reg_rd(3'd2, v); chk("R10 W1C clears only done", v, 32'h80 << (8 * ENG));
    #1 chk("R11 fill bit masked by 0x7E", irq, 1'b0);
    reg_wr(3'd3, 32'h80 << (8 * ENG)); #2 chk("R11 fill bit enabled", irq, 1'b1);
    reg_wr(3'd2, 32'hFF << (8 * ENG));
    reg_rd(3'd2, v); chk("R10 cleared", v, 32'h0);
    #1 chk("R11 irq low after clear", irq, 1'b0);

    // chain with skipped descriptor, row offset and stalls: R2 R5 R6 R11 R12
    reg_wr(3'd4, 32'd3); yoff_m = 3;
    lat_mode = 1;
    add_desc(32'h200, 0, 0, 1, 1, 1, 1, 32'h500, 32'h240, 32'h2000);
    add_desc(32'h240, 2, 2, 2, 2, 0, 7, 32'h580, 32'h280, 32'h3000);
    add_desc(32'h280, 14, 9, 15, 12, 1, 2, 32'h600, 0, 32'h4000);
    w0 = n_wr;
    reg_wr(3'd0, 32'h207);
    wait_idle();
    chk("R6 R5 chain writes all matched", q_idx.size(), 0);
    chk("R6 R12 skipped descriptor wrote nothing (stalled memory)", n_wr - w0, 12);
    reg_rd(3'd2, v); chk("R5 done at chain end", v, 32'h84 << (8 * ENG));

    // malformed descriptors: R7 R8
    reg_wr(3'd2, 32'hFF << (8 * ENG));
    add_desc(32'h300, 5, 0, 4, 0, 1, 0, 32'h700, 0, 0);
    q_idx.delete(); q_dat.delete(); q_tid.delete();
    w0 = n_wr;
    reg_wr(3'd0, 32'h300); wait_idle();
    reg_rd(3'd1, v); chk("R7 R8 error on x1<x0", v, 32'h3);
    reg_rd(3'd2, v); chk("R7 error and fill bits", v, 32'h88 << (8 * ENG));
    chk("R7 no writes", n_wr - w0, 0);
    mem[32'h340] = 0; mem[32'h344] = (1 << 16) | 16; mem[32'h348] = 1; mem[32'h350] = 0;
    reg_wr(3'd0, 32'h340); wait_idle();
    reg_rd(3'd1, v); chk("R7 error on x1 past width", v, 32'h3);
    mem[32'h380] = 0; mem[32'h384] = (13 << 16); mem[32'h388] = 1; mem[32'h390] = 0;
    reg_wr(3'd0, 32'h380); wait_idle();
    reg_rd(3'd1, v); chk("R7 error on row offset overflow", v, 32'h3);
    chk("R7 still no writes", n_wr - w0, 0);
    add_desc(32'h3C0, 4, 4, 4, 4, 1, 3, 32'h800, 32'h380, 32'h5000);
    reg_wr(3'd0, 32'h3C0); wait_idle();
    chk("R7 good head then error", n_wr - w0, 1);
    reg_rd(3'd1, v); chk("R7 error mid chain", v, 32'h3);
    add_desc(32'h100, 1, 2, 3, 3, 1, 5, 32'h400, 0, 32'h1000);
    reg_wr(3'd0, 32'h100); wait_idle();
    reg_rd(3'd1, v); chk("R8 error cleared by new start", v, 32'h1);

    // cancel mid rectangle: R9
    reg_wr(3'd4, 32'd0); yoff_m = 0;
    reg_wr(3'd2, 32'hFF << (8 * ENG));
    add_desc(32'hA00, 0, 0, 7, 7, 1, 9, 32'h1000, 0, 32'h6000);
    w0 = n_wr;
    reg_wr(3'd0, 32'hA00);
    while (n_wr - w0 < 5) @(negedge clk);
    reg_wr(3'd0, 32'h0);
    q_idx.delete(); q_dat.delete(); q_tid.delete();
    w0 = n_wr;
    repeat (30) @(negedge clk);
    chk("R9 no writes after cancel", n_wr - w0, 0);
    #2 chk("R9 no request after cancel", mem_req, 1'b0);
    reg_rd(3'd1, v); chk("R9 ready after cancel", v, 32'h1);
    reg_rd(3'd2, v); chk("R9 done not set", v & (32'h04 << (8 * ENG)), 32'h0);

    finish();
  end
endmodule